// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block paces the clock line of an I2C master from a fast peripheral clock. An 11-bit divider is assembled from two configuration fields. The low five bits share a control field with an enable bit and a speed-profile bit, and the upper six bits come from a separate extension field. From the divider the block derives a low-phase and a high-phase length. Standard mode splits the period evenly and runs near 100 kHz. Fast mode makes the low phase about twice the high phase and runs near 400 kHz. A rate field gives the peripheral clock in units of 20 MHz plus one, and it sets a floor on how early in the low phase the data line may change.

A byte engine requests one bit period at a time with a one-cycle strobe. The block pulls SCL low for the low phase and then releases it. If a slave holds the line low, the high phase does not start counting until the line is seen high. During each bit the block marks the point where SDA may be changed and the point where SDA is sampled, and it flags the last cycle of the bit. A strobe that arrives while a bit is in progress is remembered, so the next bit follows with no idle cycle. Clearing the enable parks the generator with SCL released.

Top module: `scl_timing_gen`

## Requirements
- R1: The divider D is {div_ext_i[5:0], clk_ctl_i[4:0]}, and low_cycles_o equals D+2 in both modes.
- R2: With clk_ctl_i[6]=0 (standard), high_cycles_o equals D+2.
- R3: With clk_ctl_i[6]=1 (fast), high_cycles_o equals floor((D+1)/2)+1.
- R4: After a bit_go_i strobe is accepted from idle, scl_pull_o is 1 from the next cycle for exactly low_cycles_o cycles, and then it is 0 for the high phase.
- R5: While SCL is released and scl_i reads 0, the high-phase count does not advance, and neither smp_tick_o nor bit_end_o is raised.
- R6: sda_tick_o pulses exactly once per low phase. Counting the first low cycle as 0, it falls at offset max(floor(low/2), clk_rate_i), clamped to low-1.
- R7: smp_tick_o pulses once per high phase, on the counted high cycle with index floor(high/2). Only cycles with scl_i=1 are counted, starting from 0.
- R8: bit_end_o pulses on the last counted high cycle. If a bit_go_i strobe was seen during that bit, scl_pull_o is 1 on the next cycle. Otherwise the block goes idle with scl_pull_o=0.
- R9: With clk_ctl_i[5]=0 (disabled), scl_pull_o and all ticks are 0 from the next cycle on. A bit_go_i strobe given while disabled is dropped and is not acted on after the block is enabled again.
- R10: During and right after reset, scl_pull_o, sda_tick_o, smp_tick_o and bit_end_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ctl_i | input | 7 | [4:0] divider low bits, [5] enable, [6] fast profile |
| div_ext_i | input | 6 | Divider bits [10:5] |
| clk_rate_i | input | 5 | Peripheral clock rate in 20 MHz units plus one |
| bit_go_i | input | 1 | One-cycle request for one bit period |
| scl_i | input | 1 | Synchronized level of the SCL line |
| scl_pull_o | output | 1 | 1 drives SCL low, 0 releases it |
| sda_tick_o | output | 1 | Point in the low phase where SDA may change |
| smp_tick_o | output | 1 | Point in the high phase where SDA is sampled |
| bit_end_o | output | 1 | Last counted cycle of the bit |
| low_cycles_o | output | 12 | Current low-phase length in clocks |
| high_cycles_o | output | 12 | Current high-phase length in clocks |

## Verification
The bench runs single bits over a table of divider, mode and rate settings. Equal and uneven divider values separate the standard split from the fast split and show how the odd-divider rounding in fast mode comes out. The smallest and largest dividers check the edge widths. Rate values below and above half the low phase show the SDA point following the half-way point in one case and the rate floor, with its clamp, in the other. Further bits hold SCL low by a slave, chain a second strobe into a running bit, and drop the enable in the middle of a low phase. These separate stalling from counting, back-to-back bits from return to idle, and a dropped request from a remembered one.

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int DIV_LO_W = 5,
  parameter int DIV_HI_W = 6,
  parameter int RATE_W   = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DIV_LO_W+1:0]          clk_ctl_i,
  input  logic [DIV_HI_W-1:0]          div_ext_i,
  input  logic [RATE_W-1:0]            clk_rate_i,
  input  logic                         bit_go_i,
  input  logic                         scl_i,
  output logic                         scl_pull_o,
  output logic                         sda_tick_o,
  output logic                         smp_tick_o,
  output logic                         bit_end_o,
  output logic [DIV_LO_W+DIV_HI_W:0]   low_cycles_o,
  output logic [DIV_LO_W+DIV_HI_W:0]   high_cycles_o
);
  localparam int DIV_W    = DIV_LO_W + DIV_HI_W;
  localparam int CNT_W    = DIV_W + 1;
  localparam int EN_BIT   = DIV_LO_W;
  localparam int FAST_BIT = DIV_LO_W + 1;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic             pend;

  wire [DIV_W-1:0] div  = {div_ext_i, clk_ctl_i[DIV_LO_W-1:0]};
  wire             en   = clk_ctl_i[EN_BIT];
  wire             fast = clk_ctl_i[FAST_BIT];

  wire [CNT_W-1:0] low_len  = CNT_W'(div) + CNT_W'(2);
  wire [CNT_W-1:0] fast_hi  = ((CNT_W'(div) + CNT_W'(1)) >> 1) + CNT_W'(1);
  wire [CNT_W-1:0] high_len = fast ? fast_hi : low_len;

  wire [CNT_W-1:0] half_low = low_len >> 1;
  wire [CNT_W-1:0] rate_w   = CNT_W'(clk_rate_i);
  wire [CNT_W-1:0] sda_want = (rate_w > half_low) ? rate_w : half_low;
  wire [CNT_W-1:0] sda_pos  = (sda_want > low_len - CNT_W'(1)) ? low_len - CNT_W'(1) : sda_want;
  wire [CNT_W-1:0] smp_pos  = high_len >> 1;

  wire low_last  = cnt >= low_len - CNT_W'(1);
  wire high_last = cnt >= high_len - CNT_W'(1);
  wire want      = bit_go_i | pend;

  assign low_cycles_o  = low_len;
  assign high_cycles_o = high_len;
  assign scl_pull_o    = (st == S_LOW);
  assign sda_tick_o    = (st == S_LOW) && (cnt == sda_pos);
  assign smp_tick_o    = (st == S_HIGH) && scl_i && (cnt == smp_pos);
  assign bit_end_o     = (st == S_HIGH) && scl_i && high_last;

  wire launch = en && want && ((st == S_IDLE) || bit_end_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      pend <= 1'b0;
    end else if (!en) begin
      st   <= S_IDLE;
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      pend <= want && !launch;
      case (st)
        S_IDLE: begin
          cnt <= '0;
          if (launch) st <= S_LOW;
        end
        S_LOW: begin
          if (low_last) begin
            st  <= S_HIGH;
            cnt <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_HIGH: begin
          if (scl_i) begin
            if (high_last) begin
              st  <= launch ? S_LOW : S_IDLE;
              cnt <= '0;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
        end
        default: begin
          st  <= S_IDLE;
          cnt <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic             fast_i,
  input logic             scl_i,
  input logic             scl_pull_o,
  input logic             sda_tick_o,
  input logic             smp_tick_o,
  input logic             bit_end_o,
  input logic [CNT_W-1:0] low_cycles_o,
  input logic [CNT_W-1:0] high_cycles_o
);
  logic [CNT_W:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run <= '0;
    else if (scl_pull_o) run <= (&run) ? run : run + 1'b1;
    else                 run <= '0;
  end

  wire [CNT_W:0] low_x   = {1'b0, low_cycles_o};
  wire [CNT_W:0] high_x2 = {high_cycles_o, 1'b0};

  assert_std_split_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !fast_i) |-> high_cycles_o == low_cycles_o);

  assert_fast_split_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && fast_i) |-> (low_x == high_x2 || low_x + 1'b1 == high_x2));

  assert_low_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_pull_o) && en_i && $past(en_i)) |-> run == {1'b0, $past(low_cycles_o)});

  assert_stretch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_pull_o && !scl_i) |-> (!smp_tick_o && !bit_end_o));

  assert_sda_in_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sda_tick_o |-> scl_pull_o);

  assert_smp_in_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_tick_o |-> (!scl_pull_o && scl_i));

  assert_end_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end_o |-> (!scl_pull_o && scl_i));

  assert_disable_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!scl_pull_o && !sda_tick_o && !smp_tick_o && !bit_end_o));
endmodule

bind scl_timing_gen scl_timing_gen_chk #(.CNT_W(DIV_LO_W + DIV_HI_W + 1)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .en_i          (clk_ctl_i[DIV_LO_W]),
  .fast_i        (clk_ctl_i[DIV_LO_W+1]),
  .scl_i         (scl_i),
  .scl_pull_o    (scl_pull_o),
  .sda_tick_o    (sda_tick_o),
  .smp_tick_o    (smp_tick_o),
  .bit_end_o     (bit_end_o),
  .low_cycles_o  (low_cycles_o),
  .high_cycles_o (high_cycles_o)
);

// File: tb/scl_timing_gen_tb_top.sv
module scl_timing_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int VN = 10;
  // fast, ext, lo, rate, exp_low, exp_high, exp_sda, exp_smp
  localparam int V_FAST[VN] = '{0, 1, 0, 1, 0, 1, 0, 0, 1, 1};
  localparam int V_EXT [VN] = '{0, 0, 0, 0, 1, 1, 0, 0, 0, 63};
  localparam int V_LO  [VN] = '{3, 3, 0, 0, 8, 8, 6, 1, 7, 31};
  localparam int V_RATE[VN] = '{1, 1, 0, 0, 3, 3, 6, 9, 2, 11};
  localparam int E_LOW [VN] = '{5, 5, 2, 2, 42, 42, 8, 3, 9, 2049};
  localparam int E_HIGH[VN] = '{5, 3, 2, 1, 42, 21, 8, 3, 5, 1025};
  localparam int E_SDA [VN] = '{2, 2, 1, 1, 21, 21, 6, 2, 4, 1024};
  localparam int E_SMP [VN] = '{2, 1, 1, 0, 21, 10, 4, 1, 2, 512};

  logic        clk = 0;
  logic        rst_n = 0;
  logic [6:0]  clk_ctl = '0;
  logic [5:0]  div_ext = '0;
  logic [4:0]  clk_rate = '0;
  logic        bit_go = 0;
  logic        stretch = 0;
  logic        scl_pull, sda_tick, smp_tick, bit_end;
  logic [11:0] low_cycles, high_cycles;
  wire         scl_line = !scl_pull && !stretch;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_timing_gen dut_i (
    .clk(clk), .rst_n(rst_n), .clk_ctl_i(clk_ctl), .div_ext_i(div_ext),
    .clk_rate_i(clk_rate), .bit_go_i(bit_go), .scl_i(scl_line),
    .scl_pull_o(scl_pull), .sda_tick_o(sda_tick), .smp_tick_o(smp_tick),
    .bit_end_o(bit_end), .low_cycles_o(low_cycles), .high_cycles_o(high_cycles)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_bit(input int stall, input bit chain,
                         output int lo, output int sda_at, output int sda_n,
                         output int hi, output int smp_at);
    bit_go = 1;
    @(negedge clk);
    bit_go = 0;
    lo = 0; sda_at = -1; sda_n = 0;
    while (scl_pull) begin
      bit_go = chain && (lo == 1);
      #1;
      if (sda_tick) begin sda_at = lo; sda_n++; end
      lo++;
      @(negedge clk);
    end
    bit_go = 0;
    hi = 0; smp_at = -1;
    forever begin
      stretch = (hi < stall);
      #1;
      if (smp_tick) smp_at = hi;
      hi++;
      if (bit_end) break;
      @(negedge clk);
    end
    stretch = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int lo, sda_at, sda_n, hi, smp_at, quiet;
    // R10: outputs quiet in reset
    repeat (3) @(negedge clk);
    chk("R10 pull in reset", scl_pull, 0);
    chk("R10 ticks in reset", {sda_tick, smp_tick, bit_end}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R10 pull after reset", scl_pull, 0);

    for (int i = 0; i < VN; i++) begin
      clk_ctl  = {V_FAST[i][0], 1'b1, 5'(V_LO[i])};
      div_ext  = 6'(V_EXT[i]);
      clk_rate = 5'(V_RATE[i]);
      @(negedge clk);
      chk("R1 low length field", low_cycles, E_LOW[i]);
      chk(V_FAST[i] != 0 ? "R3 fast high field" : "R2 std high field", high_cycles, E_HIGH[i]);
      run_bit(0, 0, lo, sda_at, sda_n, hi, smp_at);
      chk("R4 low phase cycles", lo, E_LOW[i]);
      chk("R6 sda tick offset", sda_at, E_SDA[i]);
      chk("R6 sda tick count", sda_n, 1);
      chk("R7 high phase cycles", hi, E_HIGH[i]);
      chk("R7 sample offset", smp_at, E_SMP[i]);
      @(negedge clk);
      chk("R8 idle after bit", scl_pull, 0);
      repeat (2) @(negedge clk);
    end

    // R5: slave stretches 3 cycles (std, D=3)
    clk_ctl = {1'b0, 1'b1, 5'd3}; div_ext = '0; clk_rate = 5'd1;
    @(negedge clk);
    run_bit(3, 0, lo, sda_at, sda_n, hi, smp_at);
    chk("R5 stretched high length", hi, 8);
    chk("R5 stretched sample offset", smp_at, 5);
    @(negedge clk);

    // R8: second strobe during low phase chains the next bit
    run_bit(0, 1, lo, sda_at, sda_n, hi, smp_at);
    @(negedge clk);
    chk("R8 chained bit starts low", scl_pull, 1);
    while (!bit_end) @(negedge clk);
    @(negedge clk);
    chk("R8 idle after chained bit", scl_pull, 0);

    // R9: drop enable mid low phase (std, D=40)
    clk_ctl = {1'b0, 1'b1, 5'd8}; div_ext = 6'd1; clk_rate = 5'd3;
    @(negedge clk);
    bit_go = 1; @(negedge clk); bit_go = 0;
    repeat (4) @(negedge clk);
    chk("R9 low before disable", scl_pull, 1);
    clk_ctl[5] = 0;
    @(negedge clk);
    chk("R9 released after disable", scl_pull, 0);
    quiet = 0;
    bit_go = 1; @(negedge clk); bit_go = 0;
    for (int k = 0; k < 20; k++) begin
      if (scl_pull || sda_tick || smp_tick || bit_end) quiet++;
      @(negedge clk);
    end
    chk("R9 no activity while disabled", quiet, 0);
    clk_ctl[5] = 1;
    for (int k = 0; k < 10; k++) begin
      if (scl_pull) quiet++;
      @(negedge clk);
    end
    chk("R9 strobe while disabled dropped", quiet, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule